// File: doc/BRIEF.md
# I2C Byte-at-a-Time Master Engine

This block is an I2C bus master that moves one byte per software handshake. A small register port with four selects gives a control register, a flag register cleared by writing zeros, an address-frame register and a data port. Writes to the data port fill the transmit byte, and reads from it return the last received byte. Software loads the address frame, which is the 7-bit target address followed by the direction bit. It then requests a START. The engine sends the frame and parks with SCL held low.

Each further byte is released by clearing the flag that paces it: the transmit-empty flag for a write, the receive-full flag for a read. A stop-request control bit ends the transfer. On a read, it is set before the final byte is released. On a write, it is set once the final byte has gone out. Bit timing comes from an external tick: each tick moves SCL by one half period. The engine reports an acknowledge refused by the target, and it reports arbitration loss when SDA reads low while the engine has released it.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, all four register selects read 0x00 and neither bus line is pulled low.
- R2: The address frame is shifted onto SDA MSB first, one bit per SCL high period. Bit 0 of the frame is the direction bit (1 = read).
- R3: In the flag register (select 1), writing 0 to a bit clears it and writing 1 leaves it as it was. Writing the inverse of one flag clears only that flag.
- R4: A control write with bit 7 (byte mode), bit 3 (enable) and bit 0 (start) all set, while the engine is idle, pulls SDA low with SCL high. SCL is held high for START_SETUP clock cycles before it first falls.
- R5: After the address frame, flag bit 0 (address sent) is set. For a write frame, flag bit 3 (transmit empty) is also set. Clearing bit 3 while waiting sends the data byte MSB first, and at its ninth clock flag bits 2 (byte sent) and 3 are set.
- R6: If SDA is high during the ninth clock of the address frame or of a written byte, flag bit 6 (acknowledge refused) is set. It stays clear when the target pulls SDA low.
- R7: On a read, clearing flag bit 1 while waiting clocks in eight bits. The byte appears on select 3, flag bit 1 is set, and the engine pulls SDA low on the ninth clock unless the byte is the last.
- R8: If control bit 1 (stop request) is set when a read byte is released, the engine leaves SDA released on that byte's ninth clock and then issues a STOP: SDA rises while SCL is high. Flag bit 4 (stop done) is set.
- R9: On a write frame, setting control bit 1 while the engine waits after a byte issues a STOP and sets flag bit 4.
- R10: If SDA reads low during an address or data bit in which the engine released it, flag bit 5 (arbitration lost) is set. Both lines are released and the engine returns to idle.
- R11: Writing the control register with bit 3 clear releases both lines within two cycles, and the engine makes no further progress. A later START works normally.
- R12: With control bit 4 set, the SCL output follows control bit 6 and the SDA output follows control bit 5, where 1 means the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_tick | input | 1 | Half-period SCL enable from an external divider |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 flags, 2 address frame, 3 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_sel |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench goes after the ninth-clock slot, because that is where acknowledge and NACK logic usually breaks. If the engine drove SDA there for a written byte, every NACK would be missed. If it failed to release SDA on the last read byte, the target would keep sending and the STOP would never appear. The bench also checks that writing ones to the flag register keeps the flags, since a write-one-to-clear mistake would wipe the handshake state. It covers the stop request in both directions: on a write it must not start another byte, and on a read it must be latched when the byte is released. Arbitration loss and abort are checked at the pins, because an engine that stays active after either would keep SCL pulled low.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  // control register bit positions
  localparam int C_START   = 0;
  localparam int C_STOPREQ = 1;
  localparam int C_EN      = 3;
  localparam int C_OVR     = 4;
  localparam int C_SDAF    = 5;
  localparam int C_SCLF    = 6;
  localparam int C_BYTE    = 7;
  // flag register bit positions
  localparam int F_ADDR    = 0;
  localparam int F_RXFULL  = 1;
  localparam int F_TXDONE  = 2;
  localparam int F_TXEMPTY = 3;
  localparam int F_STOP    = 4;
  localparam int F_LOST    = 5;
  localparam int F_NACK    = 6;
  localparam int NFLAG     = 7;

  typedef enum logic [1:0] {SEL_CTL, SEL_FLAG, SEL_ADDR, SEL_DATA} reg_sel_e;
  typedef enum logic [2:0] {E_IDLE, E_START, E_BIT, E_WAIT, E_STOP1, E_STOP2} eng_state_e;

  // write-zero-to-clear update with hardware set taking priority
  function automatic logic [NFLAG-1:0] flag_next(input logic [NFLAG-1:0] old,
                                                 input logic [NFLAG-1:0] keep,
                                                 input logic [NFLAG-1:0] set);
    return (old & keep) | set;
  endfunction
endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] ctl,
  output logic [7:0] frame,
  output logic [7:0] tx_byte,
  input  logic [7:0] rx_byte,
  input  logic       ev_addr,
  input  logic       ev_tx,
  input  logic       ev_rx,
  input  logic       ev_nack,
  input  logic       ev_lost,
  input  logic       ev_stop,
  input  logic       eng_idle,
  input  logic       eng_wait,
  output logic       start_go,
  output logic       byte_go
);
  reg_sel_e          s;
  logic [NFLAG-1:0]  flags;
  logic [NFLAG-1:0]  set_vec;
  logic              wr_ctl, wr_flag;

  assign s       = reg_sel_e'(sel);
  assign wr_ctl  = wr_en && (s == SEL_CTL);
  assign wr_flag = wr_en && (s == SEL_FLAG);

  always_comb begin
    set_vec            = '0;
    set_vec[F_ADDR]    = ev_addr;
    set_vec[F_RXFULL]  = ev_rx;
    set_vec[F_TXDONE]  = ev_tx;
    set_vec[F_TXEMPTY] = ev_tx | (ev_addr & ~frame[0]);
    set_vec[F_STOP]    = ev_stop;
    set_vec[F_LOST]    = ev_lost;
    set_vec[F_NACK]    = ev_nack;
  end

  // pacing flag cleared while the engine waits releases the next byte
  assign byte_go = wr_flag && eng_wait && ctl[C_EN] && ctl[C_BYTE] &&
                   (frame[0] ? !wdata[F_RXFULL] : !wdata[F_TXEMPTY]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl      <= '0;
      frame    <= '0;
      tx_byte  <= '0;
      flags    <= '0;
      start_go <= 1'b0;
    end else begin
      start_go <= wr_ctl && wdata[C_BYTE] && wdata[C_EN] && wdata[C_START] && eng_idle;
      if (wr_ctl) ctl <= wdata;
      if (wr_en && s == SEL_ADDR) frame <= wdata;
      if (wr_en && s == SEL_DATA) tx_byte <= wdata;
      flags <= flag_next(flags, wr_flag ? wdata[NFLAG-1:0] : '1, set_vec);
    end
  end

  always_comb begin
    unique case (s)
      SEL_CTL:  rdata = ctl;
      SEL_FLAG: rdata = {1'b0, flags};
      SEL_ADDR: rdata = frame;
      default:  rdata = rx_byte;
    endcase
  end

  // R3: no flag may appear unless it was kept or set by an event
  a_r3_w0c_keep: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag |=> ((flags & ~($past(flags & wdata[NFLAG-1:0]) | $past(set_vec))) == '0));
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int START_SETUP = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enable,
  input  logic       start_go,
  input  logic       byte_go,
  input  logic       dir_rd,
  input  logic       stop_req,
  input  logic [7:0] frame,
  input  logic [7:0] tx_byte,
  input  logic       sda_in,
  output logic       is_idle,
  output logic       is_wait,
  output logic       ev_addr,
  output logic       ev_tx,
  output logic       ev_rx,
  output logic       ev_nack,
  output logic       ev_lost,
  output logic       ev_stop,
  output logic [7:0] rx_byte,
  output logic       scl_low,
  output logic       sda_low
);
  localparam int CW = $clog2(START_SETUP + 1);

  eng_state_e      st;
  logic            hi, rxm, addr_ph, last_rx;
  logic [3:0]      bitn;
  logic [7:0]      sh;
  logic [CW-1:0]   cnt;
  logic            sample, ack_slot, lose;

  assign ack_slot = (bitn == 4'd8);
  assign sample   = enable && (st == E_BIT) && hi && tick;
  assign lose     = sample && !ack_slot && !rxm && sh[7] && !sda_in;

  assign ev_addr = sample && ack_slot && !rxm && addr_ph;
  assign ev_tx   = sample && ack_slot && !rxm && !addr_ph;
  assign ev_nack = sample && ack_slot && !rxm && sda_in;
  assign ev_rx   = sample && ack_slot && rxm;
  assign ev_lost = lose;
  assign ev_stop = enable && (st == E_STOP2) && tick;
  assign is_idle = (st == E_IDLE);
  assign is_wait = (st == E_WAIT);

  assign scl_low = ((st == E_BIT) && !hi) || (st == E_WAIT) || (st == E_STOP1);

  always_comb begin
    unique case (st)
      E_START, E_STOP1, E_STOP2: sda_low = 1'b1;
      E_BIT:   sda_low = ack_slot ? (rxm && !last_rx) : (!rxm && !sh[7]);
      default: sda_low = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= E_IDLE; hi <= 1'b0; rxm <= 1'b0; addr_ph <= 1'b0; last_rx <= 1'b0;
      bitn <= '0; sh <= '0; cnt <= '0; rx_byte <= '0;
    end else if (!enable) begin
      st <= E_IDLE;
      hi <= 1'b0;
    end else begin
      unique case (st)
        E_IDLE: if (start_go) begin
          st  <= E_START;
          cnt <= '0;
        end
        E_START: if (cnt == CW'(START_SETUP - 1)) begin
          st <= E_BIT; hi <= 1'b0; bitn <= '0; sh <= frame;
          rxm <= 1'b0; addr_ph <= 1'b1; last_rx <= 1'b0;
        end else cnt <= cnt + 1'b1;
        E_BIT: if (tick) begin
          if (!hi) hi <= 1'b1;
          else begin
            hi <= 1'b0;
            if (lose) st <= E_IDLE;
            else if (ack_slot) begin
              st <= (rxm && last_rx) ? E_STOP1 : E_WAIT;
              if (rxm) rx_byte <= sh;
            end else begin
              sh   <= {sh[6:0], sda_in};
              bitn <= bitn + 4'd1;
            end
          end
        end
        E_WAIT: if (byte_go) begin
          st <= E_BIT; hi <= 1'b0; bitn <= '0; rxm <= dir_rd;
          sh <= dir_rd ? 8'h00 : tx_byte; addr_ph <= 1'b0; last_rx <= stop_req;
        end else if (stop_req && !dir_rd) st <= E_STOP1;
        E_STOP1: if (tick) st <= E_STOP2;
        E_STOP2: if (tick) st <= E_IDLE;
        default: st <= E_IDLE;
      endcase
    end
  end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |-> (!scl_low && !sda_low));
  a_r2_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == E_BIT) && hi && $past(st == E_BIT && hi)) |-> $stable(sda_low));
  a_r10_lost_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lost |=> is_idle);
  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (is_idle && !scl_low && !sda_low));
  a_r8_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx && last_rx) |=> (st == E_STOP1));
  a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_addr, ev_tx, ev_rx, ev_lost, ev_stop}));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int START_SETUP = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_tick,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull
);
  logic [7:0] ctl, frame, tx_byte, rx_byte;
  logic ev_addr, ev_tx, ev_rx, ev_nack, ev_lost, ev_stop;
  logic eng_idle, eng_wait, start_go, byte_go, eng_scl_low, eng_sda_low;

  i2cm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .ctl(ctl), .frame(frame), .tx_byte(tx_byte), .rx_byte(rx_byte),
    .ev_addr(ev_addr), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_nack(ev_nack),
    .ev_lost(ev_lost), .ev_stop(ev_stop), .eng_idle(eng_idle), .eng_wait(eng_wait),
    .start_go(start_go), .byte_go(byte_go)
  );

  i2cm_engine #(.START_SETUP(START_SETUP)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(scl_tick), .enable(ctl[C_EN]),
    .start_go(start_go), .byte_go(byte_go), .dir_rd(frame[0]), .stop_req(ctl[C_STOPREQ]),
    .frame(frame), .tx_byte(tx_byte), .sda_in(sda_in), .is_idle(eng_idle), .is_wait(eng_wait),
    .ev_addr(ev_addr), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_nack(ev_nack), .ev_lost(ev_lost),
    .ev_stop(ev_stop), .rx_byte(rx_byte), .scl_low(eng_scl_low), .sda_low(eng_sda_low)
  );

  // R12: pin override takes the lines away from the engine
  assign scl_pull = ctl[C_OVR] ? !ctl[C_SCLF] : eng_scl_low;
  assign sda_pull = ctl[C_OVR] ? !ctl[C_SDAF] : eng_sda_low;

  a_r12_override_pins: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[C_OVR] |-> (scl_pull == !ctl[C_SCLF] && sda_pull == !ctl[C_SDAF]));
endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP = 17;

  logic clk = 1'b0, rst_n = 1'b0, scl_tick = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic sda_in, scl_pull, sda_pull;
  logic slv_pull = 1'b0, force_low = 1'b0;
  int total = 0, fails = 0, cycles = 0, tdiv = 0;

  i2c_byte_master #(.START_SETUP(SETUP)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_tick(scl_tick), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_in),
    .scl_pull(scl_pull), .sda_pull(sda_pull));

  assign sda_in = !(sda_pull || slv_pull || force_low);
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    scl_tick <= (tdiv == 3);
  end

  // target model on the wired bus
  logic [7:0] cap [0:7];
  logic [7:0] rdb [0:7];
  logic       mack [0:7];
  logic [7:0] sh = 8'h00;
  logic scl_q = 1'b1, sda_q = 1'b1, rd_dir = 1'b0, rd_end = 1'b0, in_start = 1'b0;
  int bitcnt = 0, bidx = 0, nack_idx = -1, stops = 0, start_len = 0;

  always @(negedge clk) begin
    logic scl_l, sda_l;
    scl_l = !scl_pull;
    sda_l = sda_in;
    if (scl_l && scl_q && sda_q && !sda_l) begin
      bitcnt = 0; bidx = 0; rd_dir = 1'b0; rd_end = 1'b0; slv_pull <= 1'b0;
      in_start = 1'b1; start_len = 0;
    end
    if (scl_l && scl_q && !sda_q && sda_l) stops++;
    if (in_start && scl_l && !sda_l) start_len++;
    if (!scl_q && scl_l && bidx < 8) begin
      if (bitcnt < 8) begin
        sh = {sh[6:0], sda_l};
        if (bitcnt == 7) begin
          cap[bidx] = sh;
          if (bidx == 0) rd_dir = sda_l;
        end
      end else begin
        mack[bidx] = sda_l;
        if (rd_dir && bidx > 0 && sda_l) rd_end = 1'b1;
      end
      bitcnt++;
    end
    if (scl_q && !scl_l) begin
      in_start = 1'b0;
      if (bitcnt == 9) begin bitcnt = 0; bidx++; end
      if (bitcnt == 8 && (bidx == 0 || !rd_dir)) slv_pull <= (bidx != nack_idx);
      else if (rd_dir && !rd_end && bidx > 0 && bidx < 9 && bitcnt < 8)
        slv_pull <= !rdb[bidx-1][7-bitcnt];
      else slv_pull <= 1'b0;
    end
    scl_q = scl_l;
    sda_q = sda_l;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic wait_flag(input int b, input string tag);
    logic [7:0] v;
    for (int n = 0; n < 4000; n++) begin
      rd(2'd1, v);
      if (v[b]) return;
    end
    check(1'b0, tag, 0, 1);
  endtask

  task automatic cleanup();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, fr, d;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      check(v == 8'h00, "R1 reg reset", v, 0);
    end
    check(!scl_pull && !sda_pull, "R1 lines released", {scl_pull, sda_pull}, 0);

    // R12 pin override
    wr(2'd0, 8'h30); #1 check({scl_pull, sda_pull} == 2'b10, "R12 scl forced low", {scl_pull, sda_pull}, 2);
    wr(2'd0, 8'h50); #1 check({scl_pull, sda_pull} == 2'b01, "R12 sda forced low", {scl_pull, sda_pull}, 1);
    wr(2'd0, 8'h70); #1 check({scl_pull, sda_pull} == 2'b00, "R12 both released", {scl_pull, sda_pull}, 0);
    cleanup();

    // write sweep: R2 R4 R5 R6 R9
    for (int k = 0; k < 4; k++) begin
      fr = {7'((k * 45 + 19) & 8'h7f), 1'b0};
      s0 = stops;
      wr(2'd2, fr);
      wr(2'd0, 8'h89);
      wait_flag(0, "R2 address sent flag");
      check(cap[0] == fr, "R2 address frame on bus", cap[0], fr);
      check(start_len == SETUP, "R4 start setup length", start_len, SETUP);
      rd(2'd1, v);
      check(v[3] && !v[6], "R5 empty set, R6 no nack", v, 8'h09);
      for (int i = 0; i < 2; i++) begin
        d = 8'((fr * 7 + i * 91) & 8'hff);
        wr(2'd3, d);
        wr(2'd1, 8'hF3);
        wait_flag(2, "R5 byte sent flag");
        check(cap[i+1] == d, "R5 data byte on bus", cap[i+1], d);
      end
      wr(2'd0, 8'h8A);
      wait_flag(4, "R9 stop flag");
      check(stops == s0 + 1, "R9 stop on bus", stops - s0, 1);
      if (k == 3) begin
        // R3 write-zero-to-clear
        rd(2'd1, v);
        check(v == 8'h1D, "R3 flags before clearing", v, 8'h1D);
        wr(2'd1, 8'hFF); rd(2'd1, v);
        check(v == 8'h1D, "R3 ones keep flags", v, 8'h1D);
        wr(2'd1, 8'hFB); rd(2'd1, v);
        check(v == 8'h19, "R3 clear one flag", v, 8'h19);
        wr(2'd1, 8'h00); rd(2'd1, v);
        check(v == 8'h00, "R3 zeros clear all", v, 0);
      end
      cleanup();
    end

    // R6 address refused
    nack_idx = 0;
    wr(2'd2, 8'h78); wr(2'd0, 8'h89);
    wait_flag(0, "R6 address sent");
    rd(2'd1, v);
    check(v[6], "R6 nack on address", v[6], 1);
    wr(2'd0, 8'h8A); wait_flag(4, "R9 stop after nack");
    cleanup();
    // R6 data refused
    nack_idx = 1;
    wr(2'd2, 8'h42); wr(2'd0, 8'h89);
    wait_flag(0, "R6 address sent");
    rd(2'd1, v);
    check(!v[6], "R6 address acked", v[6], 0);
    wr(2'd3, 8'h5A); wr(2'd1, 8'hF3);
    wait_flag(2, "R6 byte sent");
    rd(2'd1, v);
    check(v[6], "R6 nack on data", v[6], 1);
    wr(2'd0, 8'h8A); wait_flag(4, "R9 stop");
    cleanup();
    nack_idx = -1;

    // read sweep: R7 R8
    for (int k = 0; k < 3; k++) begin
      fr = {7'((k * 29 + 33) & 8'h7f), 1'b1};
      for (int j = 0; j < 3; j++) rdb[j] = 8'((k * 97 + j * 59 + 165) & 8'hff);
      s0 = stops;
      wr(2'd2, fr); wr(2'd0, 8'h89);
      wait_flag(0, "R7 address sent");
      for (int j = 0; j <= k; j++) begin
        wr(2'd0, (j == k) ? 8'h8A : 8'h88);
        wr(2'd1, 8'hFD);
        wait_flag(1, "R7 receive flag");
        rd(2'd3, v);
        check(v == rdb[j], "R7 received byte", v, rdb[j]);
      end
      wait_flag(4, "R8 stop flag");
      for (int j = 0; j <= k; j++)
        check(mack[j+1] == (j == k), (j == k) ? "R8 last byte released" : "R7 byte acked",
              mack[j+1], (j == k));
      check(stops == s0 + 1, "R8 stop on bus", stops - s0, 1);
      cleanup();
    end

    // R10 arbitration lost
    wr(2'd2, 8'hA0);
    force_low = 1'b1;
    wr(2'd0, 8'h89);
    wait_flag(5, "R10 lost flag");
    repeat (2) @(negedge clk);
    check(!scl_pull && !sda_pull, "R10 lines released", {scl_pull, sda_pull}, 0);
    rd(2'd1, v);
    check(!v[0], "R10 no address flag", v[0], 0);
    force_low = 1'b0;
    cleanup();

    // R11 abort mid-byte
    wr(2'd2, 8'h44); wr(2'd0, 8'h89);
    wait_flag(0, "R11 address sent");
    wr(2'd3, 8'hFF); wr(2'd1, 8'hF3);
    repeat (20) @(negedge clk);
    wr(2'd0, 8'h00);
    repeat (2) @(negedge clk);
    check(!scl_pull && !sda_pull, "R11 lines released", {scl_pull, sda_pull}, 0);
    wr(2'd1, 8'h00);
    repeat (300) @(negedge clk);
    rd(2'd1, v);
    check(v == 8'h00, "R11 no progress", v, 0);
    wr(2'd2, 8'h2C); wr(2'd0, 8'h89);
    wait_flag(0, "R11 restart");
    check(cap[0] == 8'h2C, "R11 restart frame", cap[0], 8'h2C);
    wr(2'd0, 8'h8A); wait_flag(4, "R11 stop");
    cleanup();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule